// File: doc/BRIEF.md
# Bit-Count Rank Selector

This block picks one order statistic from a window of unsigned pixel words. It does not sort the words. Every bit position has its own narrow accumulator, which counts how many window words carry a 1 in that position. Once the last word of the window is in, each count is compared with a threshold set by the requested rank. The comparison results, taken together, form the output word. Each bit position is handled on its own, so the result is the coordinate-logic rank of the window and not an arithmetic sort.

A window opens with a one-cycle `start_i` pulse, which also captures the requested rank. The block then takes exactly `WIN_N` words, at most one per clock, on the cycles where `word_valid_i` is high. The result is registered and stays unchanged until the next window completes. A one-cycle `valid_o` pulse marks each new result. To get the median, drive rank `(WIN_N+1)/2`. Rank 1 gives the bitwise AND of the window and rank `WIN_N` gives the bitwise OR.

Top module: `cl_rank_sel`

## Requirements
- R1: Each bit position keeps its own count of the accepted words that carry a 1 in that position. No count ever exceeds `WIN_N`, which is at most 31 and fits a 5-bit count.
- R2: A window is exactly `WIN_N` accepted words. A word is accepted only on a cycle where a window is open, `word_valid_i` is high and `start_i` is low. Cycles with `word_valid_i` low stall the window without affecting it.
- R3: `start_i` clears all counts and the word count and opens a new window, even in the middle of a window. The word presented in the start cycle is not accepted.
- R4: `rank_i` is captured in the start cycle as an ascending rank r, where 1 is the smallest. A value of 0 is treated as rank 1, and any value above `WIN_N` is treated as rank `WIN_N`.
- R5: For rank r, result bit b is 1 exactly when count_b ≥ `WIN_N` − r + 1. Rank 1 therefore yields the bitwise AND of the window, rank `WIN_N` yields the bitwise OR, and rank (`WIN_N`+1)/2 yields the per-bit median.
- R6: `result_o` and `valid_o` update at the clock edge that accepts the last word of the window. `valid_o` is high for that one cycle only.
- R7: `result_o` holds its value until the next window completes. Words presented while no window is open are ignored.
- R8: After reset, `result_o` is 0, `valid_o` is 0 and no window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a new window and captures the rank |
| rank_i | input | $clog2(WIN_N+1) | Requested ascending rank, captured at start |
| word_valid_i | input | 1 | The window word on `word_i` is present this cycle |
| word_i | input | DATA_W | Window word |
| result_o | output | DATA_W | Rank result, held between windows |
| valid_o | output | 1 | One-cycle pulse when a new result is available |

## Verification
The assertions assume that `start_i` is a single-cycle pulse and that no more than `WIN_N` words arrive between pulses. They also assume that `rank_i` is stable in the start cycle. The stimulus follows these rules: it always opens a window with a one-cycle start, and it then feeds exactly the window length, with random idle gaps in between. The two deliberate departures are words sent while no window is open and a restart after only part of a window. Both are legal input sequences under R3 and R7.

// File: rtl/cl_rank_pkg.sv
package cl_rank_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_ACC  = 1'b1
  } seq_state_e;

  localparam int unsigned MAX_WIN = 31;
endpackage

// File: rtl/rank_threshold.sv
module rank_threshold #(
  parameter int unsigned WIN_N = 9,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] rank_i,
  output logic [CNT_W-1:0] thr_o
);
  logic [CNT_W-1:0] rank_c;
  logic [CNT_W-1:0] thr_d;

  // clamp rank into 1..WIN_N
  always_comb begin
    if (rank_i == '0)                      rank_c = CNT_W'(1);
    else if (rank_i > CNT_W'(WIN_N))       rank_c = CNT_W'(WIN_N);
    else                                   rank_c = rank_i;
    thr_d = CNT_W'(32'(WIN_N) + 32'd1 - 32'(rank_c));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     thr_o <= CNT_W'(WIN_N);
    else if (load_i) thr_o <= thr_d;
  end
endmodule

// File: rtl/window_seq.sv
module window_seq
  import cl_rank_pkg::*;
#(
  parameter int unsigned WIN_N = 9,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             word_valid_i,
  output logic             acc_en_o,
  output logic             last_o,
  output logic [CNT_W-1:0] word_cnt_o
);
  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  assign acc_en_o   = (state_q == ST_ACC) && word_valid_i && !start_i;
  assign last_o     = acc_en_o && (cnt_q == CNT_W'(WIN_N - 1));
  assign word_cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (start_i) begin
      state_q <= ST_ACC;
      cnt_q   <= '0;
    end else if (last_o) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (acc_en_o) begin
      cnt_q   <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/bit_counter.sv
module bit_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             bit_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] sum;

  // single bit added into a narrow accumulator
  assign sum   = cnt_q + CNT_W'(bit_i);
  assign hit_o = (sum >= thr_i);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= sum;
  end
endmodule

// File: rtl/cl_rank_sel.sv
module cl_rank_sel #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned WIN_N  = 9,
  localparam int unsigned CNT_W = $clog2(WIN_N + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  rank_i,
  input  logic              word_valid_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o
);
  logic                    acc_en;
  logic                    last;
  logic [CNT_W-1:0]        word_cnt;
  logic [CNT_W-1:0]        thr_q;
  logic [DATA_W-1:0]       hit;
  logic [DATA_W*CNT_W-1:0] cnt_flat;
  logic [DATA_W-1:0]       result_q;
  logic                    valid_q;

  window_seq #(.WIN_N(WIN_N), .CNT_W(CNT_W)) i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .word_valid_i (word_valid_i),
    .acc_en_o     (acc_en),
    .last_o       (last),
    .word_cnt_o   (word_cnt)
  );

  rank_threshold #(.WIN_N(WIN_N), .CNT_W(CNT_W)) i_thr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_i),
    .rank_i (rank_i),
    .thr_o  (thr_q)
  );

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    bit_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (start_i),
      .en_i   (acc_en),
      .bit_i  (word_i[b]),
      .thr_i  (thr_q),
      .cnt_o  (cnt_flat[b*CNT_W +: CNT_W]),
      .hit_o  (hit[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= last;
      if (last) result_q <= hit;
    end
  end

  assign result_o = result_q;
  assign valid_o  = valid_q;
endmodule

// File: rtl/cl_rank_sel_chk.sv
module cl_rank_sel_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned WIN_N  = 9,
  parameter int unsigned CNT_W  = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    start_i,
  input logic                    valid_o,
  input logic [DATA_W-1:0]       result_o,
  input logic [CNT_W-1:0]        word_cnt,
  input logic [CNT_W-1:0]        thr_q,
  input logic [DATA_W*CNT_W-1:0] cnt_flat
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_chk
    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_flat[b*CNT_W +: CNT_W] <= CNT_W'(WIN_N)); // R1
  end

  AST_WORD_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_cnt < CNT_W'(WIN_N)); // R2

  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (word_cnt == '0) && (cnt_flat == '0) && !valid_o); // R3

  AST_THR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_q >= CNT_W'(1)) && (thr_q <= CNT_W'(WIN_N))); // R4

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R6

  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(result_o)); // R7
endmodule

bind cl_rank_sel cl_rank_sel_chk #(
  .DATA_W (DATA_W),
  .WIN_N  (WIN_N),
  .CNT_W  (CNT_W)
) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .valid_o  (valid_o),
  .result_o (result_o),
  .word_cnt (word_cnt),
  .thr_q    (thr_q),
  .cnt_flat (cnt_flat)
);

// File: tb/test_cl_rank_sel.sv
`timescale 1ns/1ps
module test_cl_rank_sel;
  localparam int DW = 8;
  localparam int N  = 9;
  localparam int RW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [RW-1:0] rank = '0;
  logic          wvalid = 1'b0;
  logic [DW-1:0] word = '0;
  logic [DW-1:0] result;
  logic          valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [DW-1:0] win [N];

  always #5 clk = ~clk;

  cl_rank_sel i_cl_rank_sel (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .start_i      (start),
    .rank_i       (rank),
    .word_valid_i (wvalid),
    .word_i       (word),
    .result_o     (result),
    .valid_o      (valid)
  );

  function automatic logic [DW-1:0] model(int r_in);
    int r, thr, c;
    logic [DW-1:0] e;
    r   = (r_in < 1) ? 1 : (r_in > N) ? N : r_in;
    thr = N - r + 1;
    for (int b = 0; b < DW; b++) begin
      c = 0;
      for (int i = 0; i < N; i++) c += int'(win[i][b]);
      e[b] = (c >= thr);
    end
    return e;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // start pulse carries a junk word (R3), then N words with random gaps
  task automatic run_window(input int r_in, input int gap_max, input string req);
    logic [DW-1:0] exp, held;
    exp = model(r_in);
    @(negedge clk);
    start = 1'b1; rank = RW'(r_in); wvalid = 1'b1; word = '1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < N; i++) begin
      int g;
      g = (gap_max > 0) ? int'($urandom_range(gap_max, 0)) : 0;
      for (int j = 0; j < g; j++) begin
        wvalid = 1'b0; word = DW'($urandom);
        @(negedge clk);
      end
      wvalid = 1'b1; word = win[i];
      @(negedge clk);
    end
    wvalid = 1'b0;
    check({req, " valid pulse R6"}, DW'(valid), DW'(1));
    check(req, result, exp);
    held = result;
    @(negedge clk);
    check("R6 valid one cycle", DW'(valid), DW'(0));
    check("R7 result held", result, held);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R8 reset result", result, '0);
    check("R8 reset valid", DW'(valid), DW'(0));
    rst_n = 1'b1;
    @(negedge clk);

    // words while idle have no effect (R2, R7)
    wvalid = 1'b1;
    for (int i = 0; i < N + 2; i++) begin word = '1; @(negedge clk); end
    wvalid = 1'b0;
    check("R7 idle words valid", DW'(valid), DW'(0));
    check("R7 idle words result", result, '0);

    // directed: AND / OR / median
    for (int i = 0; i < N; i++) win[i] = DW'($urandom);
    run_window(1, 0, "R5 rank1 AND");
    run_window(N, 2, "R5 rankN OR");
    run_window((N + 1) / 2, 1, "R5 median");
    run_window(0, 0, "R4 rank0 clamp");
    run_window((1 << RW) - 1, 0, "R4 rank high clamp");
    for (int i = 0; i < N; i++) win[i] = 8'h5A;
    run_window(3, 3, "R1 uniform window");
    for (int i = 0; i < N; i++) win[i] = (i < 4) ? 8'hFF : 8'h00;
    run_window(5, 0, "R5 threshold edge low");
    run_window(6, 0, "R5 threshold edge high");

    // idle after result: words ignored, result held (R7)
    begin
      logic [DW-1:0] h;
      h = result;
      wvalid = 1'b1;
      for (int i = 0; i < 5; i++) begin word = DW'($urandom); @(negedge clk); end
      wvalid = 1'b0;
      check("R7 post-window idle", result, h);
      check("R7 post-window valid", DW'(valid), DW'(0));
    end

    // partial window then restart (R3)
    @(negedge clk);
    start = 1'b1; rank = RW'(N); wvalid = 1'b0;
    @(negedge clk);
    start = 1'b0; wvalid = 1'b1; word = '1;
    repeat (N - 2) @(negedge clk);
    wvalid = 1'b0;
    check("R2 no early valid", DW'(valid), DW'(0));
    for (int i = 0; i < N; i++) win[i] = 8'h01 << (i % 8);
    run_window(N, 1, "R3 restart discards partial");

    // random windows
    for (int t = 0; t < 60; t++) begin
      for (int i = 0; i < N; i++)
        win[i] = (t % 3 == 0) ? DW'($urandom & $urandom) : DW'($urandom);
      run_window(int'($urandom_range((1 << RW) - 1, 0)), 3, "R5 random");
    end

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule